// File: doc/BRIEF.md
# Four-Channel Window Alarm with Hysteresis

This block watches a stream of 12-bit conversion results. Each result arrives with a valid strobe and a 3-bit channel number. Results on the four lowest channels are compared against a per-channel upper bound and lower bound. Results on the upper four channels pass by with no effect. A violation makes the channel active on that side and sets a sticky status bit. The active state drops only when a later result comes back inside the window by a programmable hysteresis margin. The margin saturates at the ends of the code range.

The host programs the block through a write port and a combinational read port, both 4-bit addressed. The control register holds the alert enable, a spare bit and the alert polarity. The alert output is modelled as an open-drain pull-down enable. A separate flag reports whether any monitored channel is active, and it is meant to be packed into the result word. Writing the all-ones hysteresis code turns a channel's bound pair into capture storage: the upper bound then holds the largest result seen on that channel and the lower bound the smallest, and the channel raises no alarm.

Address map: 0 control (bit 2 alert enable, bit 1 spare, bit 0 polarity, 1 = active high), 1 status, 4+k lower bound of channel k, 8+k upper bound of channel k, 12+k hysteresis of channel k (k = 0..3 for res_ch 0..3). Addresses 2 and 3 are unused.

Top module: `range_watch`

## Requirements
- R1: After reset the upper bounds read 4095, the lower bounds 0, the hysteresis values 8, and control and status 0. With these values alert_flag is 0 and alert_pd is 0.
- R2: A valid result on res_ch k (k < 4) with a value strictly above that channel's upper bound makes the high side of channel k active from the next cycle. A value equal to the bound does not.
- R3: A valid result on res_ch k (k < 4) with a value strictly below the lower bound makes the low side active from the next cycle. A value equal to the bound does not.
- R4: An active high side drops on a result at or below (upper bound − hysteresis), floored at 0. An active low side drops on a result at or above (lower bound + hysteresis), capped at 4095. Results between the bound and the release point leave the side active.
- R5: Results with res_ch 4 to 7 change no register, status bit, flag or pin.
- R6: Status bit 2k records a low violation and bit 2k+1 a high violation of res_ch k. Bits stay set after the channel releases, and they accumulate across channels until cleared.
- R7: Writing 0xFF to address 1, or writing the control register with bits 2 and 1 both 1, clears all status bits and all active sides. A status write of any other value changes nothing.
- R8: A violation in the same cycle as a clear still leaves its status bit and active side set.
- R9: While a channel's hysteresis is 4095, each result above its upper bound replaces that bound and each result below its lower bound replaces that bound. The channel's active sides are 0 from the next cycle, and its results set no status bit.
- R10: alert_pd equals control bit 0 XOR (control bit 2 AND any active side). With the default polarity (bit 0 = 0) this means the pin is pulled low while an alert is active.
- R11: alert_flag is 1 whenever any side of any of the four channels is active, whatever the enable bit.
- R12: Registers read back at the addresses given above, zero-extended. Addresses 2 and 3 read 0 and ignore writes. A host write to a bound takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_vld | input | 1 | Conversion result valid strobe |
| res_ch | input | 3 | Channel of the result (0..7) |
| res_data | input | 12 | Result code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 12 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 12 | Register read data, combinational |
| alert_flag | output | 1 | Any monitored channel active |
| alert_pd | output | 1 | Open-drain pull-down enable for the alert pin |

## Verification
Two functions can land in the same cycle: a status clear and a new violation. The clear may come from a status write or from a control write. The directed part issues both in one cycle and expects the new status bit and active side to survive while older bits vanish. A second collision is a host write to a bound in the cycle a min/max capture would update it; the host value must win. The random part mixes results near the bounds with writes of every kind, so these collisions also recur at random and are judged against a cycle model in the bench.

// File: rtl/range_watch_pkg.sv
`timescale 1ns/1ps
package range_watch_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [1:0] {
    GRP_CTRL = 2'd0,
    GRP_LOW  = 2'd1,
    GRP_HIGH = 2'd2,
    GRP_HYST = 2'd3
  } grp_e;

  localparam logic [1:0] SLOT_CFG = 2'd0;
  localparam logic [1:0] SLOT_STS = 2'd1;

  function automatic grp_e grp_of(input logic [ADDR_W-1:0] a);
    return grp_e'(a[3:2]);
  endfunction
endpackage

// File: rtl/rw_chan.sv
`timescale 1ns/1ps
module rw_chan #(
  parameter int DW       = 12,
  parameter int HYST_RST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit,
  input  logic [DW-1:0] data,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic          wr_hy,
  input  logic [DW-1:0] wr_val,
  input  logic          clr,
  output logic [DW-1:0] lo_q,
  output logic [DW-1:0] hi_q,
  output logic [DW-1:0] hy_q,
  output logic          act_lo,
  output logic          act_hi,
  output logic          set_lo,
  output logic          set_hi
);
  localparam logic [DW-1:0] FULL    = {DW{1'b1}};
  localparam logic [DW-1:0] HY_INIT = DW'(HYST_RST);

  logic [DW:0]   hi_gap, lo_gap;
  logic [DW-1:0] hi_rel_pt, lo_rel_pt;
  logic          minmax, rel_hi, rel_lo, cap_hi, cap_lo;
  logic          act_hi_d, act_lo_d;
  logic          hi_en, lo_en;
  logic [DW-1:0] hi_d, lo_d;

  // release points, saturated at the ends of the code range
  always_comb begin
    hi_gap    = {1'b0, hi_q} - {1'b0, hy_q};
    hi_rel_pt = hi_gap[DW] ? '0 : hi_gap[DW-1:0];
    lo_gap    = {1'b0, lo_q} + {1'b0, hy_q};
    lo_rel_pt = lo_gap[DW] ? FULL : lo_gap[DW-1:0];
  end

  assign minmax = (hy_q == FULL);
  assign set_hi = hit & ~minmax & (data > hi_q);
  assign set_lo = hit & ~minmax & (data < lo_q);
  assign rel_hi = hit & (data <= hi_rel_pt);
  assign rel_lo = hit & (data >= lo_rel_pt);
  assign cap_hi = hit & minmax & (data > hi_q);
  assign cap_lo = hit & minmax & (data < lo_q);

  // next state: a fresh violation beats a clear
  always_comb begin
    act_hi_d = act_hi;
    if (minmax)              act_hi_d = 1'b0;
    else if (set_hi)         act_hi_d = 1'b1;
    else if (clr || rel_hi)  act_hi_d = 1'b0;

    act_lo_d = act_lo;
    if (minmax)              act_lo_d = 1'b0;
    else if (set_lo)         act_lo_d = 1'b1;
    else if (clr || rel_lo)  act_lo_d = 1'b0;

    hi_en = wr_hi | cap_hi;
    hi_d  = wr_hi ? wr_val : data;
    lo_en = wr_lo | cap_lo;
    lo_d  = wr_lo ? wr_val : data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hi <= 1'b0;
      act_lo <= 1'b0;
    end else begin
      act_hi <= act_hi_d;
      act_lo <= act_lo_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hi_q <= FULL;
    else if (hi_en) hi_q <= hi_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lo_q <= '0;
    else if (lo_en) lo_q <= lo_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hy_q <= HY_INIT;
    else if (wr_hy) hy_q <= wr_val;
  end

  a_r2_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !minmax && (data > hi_q)) |=> act_hi);
  a_r3_low_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !minmax && (data < lo_q)) |=> act_lo);
  a_r4_high_release: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !minmax && (data <= hi_rel_pt)) |=> !act_hi);
  a_r9_no_alarm: assert property (@(posedge clk) disable iff (!rst_n)
    minmax |=> (!act_hi && !act_lo));
  a_r9_max_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && minmax && !wr_hi && (data > hi_q)) |=> (hi_q == $past(data)));
  a_r12_host_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (lo_q == $past(wr_val)));
endmodule

// File: rtl/rw_status.sv
`timescale 1ns/1ps
module rw_status #(
  parameter int NMON = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NMON-1:0]   set_lo,
  input  logic [NMON-1:0]   set_hi,
  input  logic              clr,
  output logic [2*NMON-1:0] sts_q
);
  localparam int SW = 2 * NMON;

  logic [SW-1:0] set_v;
  logic [SW-1:0] sts_d;
  logic          sts_en;

  for (genvar k = 0; k < NMON; k++) begin : g_pack
    assign set_v[2*k]   = set_lo[k];
    assign set_v[2*k+1] = set_hi[k];
  end

  always_comb begin
    sts_d  = (clr ? '0 : sts_q) | set_v;
    sts_en = clr | (|set_v);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_en) sts_q <= sts_d;
  end

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (set_v == '0)) |=> (sts_q == '0));
  a_r8_set_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_v) |=> ((sts_q & $past(set_v)) == $past(set_v)));
endmodule

// File: rtl/range_watch.sv
`timescale 1ns/1ps
module range_watch
  import range_watch_pkg::*;
#(
  parameter int DW       = 12,
  parameter int CHW      = 3,
  parameter int NMON     = 4,
  parameter int HYST_RST = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_vld,
  input  logic [CHW-1:0]    res_ch,
  input  logic [DW-1:0]     res_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              alert_flag,
  output logic              alert_pd
);
  localparam int SW = 2 * NMON;

  logic [NMON-1:0] hit, wr_lo, wr_hi, wr_hy;
  logic [NMON-1:0] act_lo, act_hi, set_lo, set_hi;
  logic [DW-1:0]   lo_a [NMON];
  logic [DW-1:0]   hi_a [NMON];
  logic [DW-1:0]   hy_a [NMON];
  logic [SW-1:0]   sts_q;
  logic [2:0]      cfg_q, cfg_d;
  logic            cfg_we, sts_we, clr, any_act;
  grp_e            wgrp, rgrp;
  logic [1:0]      wslot, rslot;

  always_comb begin
    wgrp   = grp_of(wr_addr);
    wslot  = wr_addr[1:0];
    cfg_we = wr_en && (wgrp == GRP_CTRL) && (wslot == SLOT_CFG);
    sts_we = wr_en && (wgrp == GRP_CTRL) && (wslot == SLOT_STS);
    clr    = (cfg_we && (wr_data[2:1] == 2'b11)) ||
             (sts_we && (wr_data[7:0] == 8'hFF));
    cfg_d  = wr_data[2:0];
  end

  for (genvar k = 0; k < NMON; k++) begin : g_ch
    assign hit[k]   = res_vld && (res_ch == CHW'(k));
    assign wr_lo[k] = wr_en && (wgrp == GRP_LOW)  && (int'(wslot) == k);
    assign wr_hi[k] = wr_en && (wgrp == GRP_HIGH) && (int'(wslot) == k);
    assign wr_hy[k] = wr_en && (wgrp == GRP_HYST) && (int'(wslot) == k);

    rw_chan #(.DW(DW), .HYST_RST(HYST_RST)) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .hit    (hit[k]),
      .data   (res_data),
      .wr_lo  (wr_lo[k]),
      .wr_hi  (wr_hi[k]),
      .wr_hy  (wr_hy[k]),
      .wr_val (wr_data),
      .clr    (clr),
      .lo_q   (lo_a[k]),
      .hi_q   (hi_a[k]),
      .hy_q   (hy_a[k]),
      .act_lo (act_lo[k]),
      .act_hi (act_hi[k]),
      .set_lo (set_lo[k]),
      .set_hi (set_hi[k])
    );
  end

  rw_status #(.NMON(NMON)) u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_lo (set_lo),
    .set_hi (set_hi),
    .clr    (clr),
    .sts_q  (sts_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  assign any_act    = (|act_lo) | (|act_hi);
  assign alert_flag = any_act;
  assign alert_pd   = cfg_q[0] ^ (cfg_q[2] & any_act);

  always_comb begin
    rgrp    = grp_of(rd_addr);
    rslot   = rd_addr[1:0];
    rd_data = '0;
    case (rgrp)
      GRP_CTRL: begin
        if (rslot == SLOT_CFG)      rd_data[2:0]    = cfg_q;
        else if (rslot == SLOT_STS) rd_data[SW-1:0] = sts_q;
      end
      GRP_LOW:  if (int'(rslot) < NMON) rd_data = lo_a[rslot];
      GRP_HIGH: if (int'(rslot) < NMON) rd_data = hi_a[rslot];
      GRP_HYST: if (int'(rslot) < NMON) rd_data = hy_a[rslot];
      default:  rd_data = '0;
    endcase
  end

  a_r5_upper_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (res_vld && (res_ch >= CHW'(NMON)) && !wr_en) |=> (sts_q == $past(sts_q)));
  a_r11_flag_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_hi) |=> alert_flag);
endmodule

// File: tb/sim_range_watch.sv
`timescale 1ns/1ps
module sim_range_watch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        res_vld;
  logic [2:0]  res_ch;
  logic [11:0] res_data;
  logic        wr_en;
  logic [3:0]  wr_addr;
  logic [11:0] wr_data;
  logic [3:0]  rd_addr;
  logic [11:0] rd_data;
  logic        alert_flag;
  logic        alert_pd;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  int m_lo[4], m_hi[4], m_hy[4];
  bit m_al[4], m_ah[4];
  int m_sts, m_cfg;

  always #2 clk = ~clk;

  range_watch u0 (
    .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_ch(res_ch),
    .res_data(res_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .alert_flag(alert_flag),
    .alert_pd(alert_pd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_flag();
    int f = 0;
    for (int k = 0; k < 4; k++) if (m_al[k] || m_ah[k]) f = 1;
    return f;
  endfunction

  function automatic int exp_pd();
    return (m_cfg & 1) ^ (((m_cfg >> 2) & 1) & exp_flag());
  endfunction

  function automatic int model_read(input int a);
    if (a == 0) return m_cfg;
    if (a == 1) return m_sts;
    if (a < 4)  return 0;
    if (a < 8)  return m_lo[a-4];
    if (a < 12) return m_hi[a-8];
    return m_hy[a-12];
  endfunction

  // cycle model derived from the requirements
  task automatic model_update(input bit vld, input int ch, input int d,
                              input bit we, input int a, input int wd);
    bit clr;
    int sets = 0;
    clr = we && ((a == 0 && ((wd >> 1) & 3) == 3) || (a == 1 && (wd & 255) == 255));
    for (int k = 0; k < 4; k++) begin
      bit hitk, mm, sh, sl;
      int hc, lc;
      hitk = vld && (ch == k);
      mm   = (m_hy[k] == 4095);
      sh   = hitk && !mm && (d > m_hi[k]);
      sl   = hitk && !mm && (d < m_lo[k]);
      hc   = (m_hi[k] - m_hy[k] < 0) ? 0 : m_hi[k] - m_hy[k];
      lc   = (m_lo[k] + m_hy[k] > 4095) ? 4095 : m_lo[k] + m_hy[k];
      if (mm) m_ah[k] = 0;
      else if (sh) m_ah[k] = 1;
      else if (clr || (hitk && d <= hc)) m_ah[k] = 0;
      if (mm) m_al[k] = 0;
      else if (sl) m_al[k] = 1;
      else if (clr || (hitk && d >= lc)) m_al[k] = 0;
      if (hitk && mm && d > m_hi[k]) m_hi[k] = d;
      if (hitk && mm && d < m_lo[k]) m_lo[k] = d;
      if (sh) sets |= (1 << (2*k+1));
      if (sl) sets |= (1 << (2*k));
    end
    m_sts = (clr ? 0 : m_sts) | sets;
    if (we) begin
      if (a == 0) m_cfg = wd & 7;
      else if (a >= 4 && a < 8)  m_lo[a-4]  = wd;
      else if (a >= 8 && a < 12) m_hi[a-8]  = wd;
      else if (a >= 12)          m_hy[a-12] = wd;
    end
  endtask

  task automatic step(input bit vld, input int ch, input int d, input bit we,
                      input int a, input int wd, input string req);
    @(negedge clk);
    res_vld = vld; res_ch = ch[2:0]; res_data = d[11:0];
    wr_en = we; wr_addr = a[3:0]; wr_data = wd[11:0];
    @(posedge clk);
    #0.5;
    res_vld = 0; wr_en = 0;
    model_update(vld, ch, d & 4095, we, a, wd & 4095);
    rd_addr = 4'd1;
    #0.5;
    chk(req, "status", int'(rd_data), m_sts);
    chk(req, "alert_flag", int'(alert_flag), exp_flag());
    chk(req, "alert_pd", int'(alert_pd), exp_pd());
  endtask

  task automatic res(input int ch, input int d, input string req);
    step(1, ch, d, 0, 0, 0, req);
  endtask

  task automatic wr(input int a, input int wd, input string req);
    step(0, 0, 0, 1, a, wd, req);
  endtask

  task automatic check_reg(input int a, input string req);
    @(negedge clk);
    rd_addr = a[3:0];
    #0.5;
    chk(req, $sformatf("reg%0d", a), int'(rd_data), model_read(a));
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    for (int k = 0; k < 4; k++) begin
      m_lo[k] = 0; m_hi[k] = 4095; m_hy[k] = 8; m_al[k] = 0; m_ah[k] = 0;
    end
    m_sts = 0; m_cfg = 0;
    rst_n = 0; res_vld = 0; res_ch = 0; res_data = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 16; a++) check_reg(a, "R1");
    chk("R1", "alert_pd", int'(alert_pd), 0);
    chk("R1", "alert_flag", int'(alert_flag), 0);

    // R10 enable, active low
    wr(0, 3'b100, "R10");
    // R2 strict high bound
    wr(8, 1000, "R12");
    wr(4, 200, "R12");
    res(0, 1000, "R2");
    chk("R2", "flag_at_bound", int'(alert_flag), 0);
    res(0, 1001, "R2");
    chk("R2", "status_bit1", int'(rd_data), 2);
    chk("R10", "pd_active_low", int'(alert_pd), 1);
    // R4 hysteresis release at 992
    res(0, 993, "R4");
    chk("R4", "still_active", int'(alert_flag), 1);
    res(0, 992, "R4");
    chk("R4", "released", int'(alert_flag), 0);
    chk("R6", "sticky", int'(rd_data), 2);
    // R3 low side on channel 1, accumulates R6
    wr(5, 100, "R12");
    res(1, 100, "R3");
    res(1, 99, "R3");
    chk("R6", "accumulate", int'(rd_data), 6);
    res(1, 107, "R4");
    res(1, 108, "R4");
    // R5 upper channels
    for (int c = 4; c < 8; c++) begin
      res(c, 0, "R5");
      res(c, 4095, "R5");
    end
    check_reg(4, "R5");
    check_reg(8, "R5");
    // R7 ignored status write, then clear
    res(0, 3000, "R7");
    wr(1, 8'h7F, "R7");
    chk("R7", "ignored", int'(rd_data), 6);
    wr(1, 8'hFF, "R7");
    chk("R7", "cleared", int'(rd_data), 0);
    chk("R7", "active_dropped", int'(alert_flag), 0);
    wr(2, 12'hABC, "R12");
    check_reg(2, "R12");
    // R8 violation in clear cycle
    res(1, 5, "R8");
    step(1, 0, 2000, 1, 1, 8'hFF, "R8");
    chk("R8", "new_bit_kept", int'(rd_data), 2);
    res(1, 7, "R8");
    step(1, 1, 3, 1, 0, 3'b110, "R8");
    chk("R8", "cfg_clear_keeps_new", int'(rd_data), 4);
    // R4 saturation
    wr(14, 50, "R4");
    wr(10, 20, "R4");
    res(2, 21, "R4");
    res(2, 1, "R4");
    chk("R4", "floor_zero_hold", int'(rd_data) >> 5 & 1, 1);
    res(2, 0, "R4");
    wr(7, 4090, "R4");
    wr(15, 10, "R4");
    res(3, 4089, "R4");
    res(3, 4094, "R4");
    res(3, 4095, "R4");
    // R10 polarity, R11 flag when disabled
    res(0, 4000, "R10");
    wr(0, 3'b101, "R10");
    chk("R10", "pd_active_high", int'(alert_pd), 0);
    wr(0, 3'b001, "R11");
    chk("R11", "flag_disabled", int'(alert_flag), 1);
    chk("R10", "pd_disabled_high", int'(alert_pd), 1);
    wr(0, 3'b000, "R10");
    // R9 min/max capture
    wr(1, 8'hFF, "R9");
    wr(14, 4095, "R9");
    wr(10, 0, "R9");
    wr(6, 4095, "R9");
    res(2, 500, "R9");
    res(2, 300, "R9");
    res(2, 900, "R9");
    check_reg(10, "R9");
    check_reg(6, "R9");
    chk("R9", "no_alarm", int'(alert_flag), 0);
    // R12 host write beats capture
    step(1, 2, 3000, 1, 10, 123, "R12");
    check_reg(10, "R12");

    // constrained random mix
    for (int i = 0; i < 600; i++) begin
      int kind, k, d, base;
      kind = $urandom % 10;
      k = $urandom % 8;
      if (kind < 6) begin
        base = (k < 4) ? (($urandom % 2) ? m_hi[k] : m_lo[k]) : 2048;
        d = base + int'($urandom % 21) - 10;
        if (d < 0) d = 0;
        if (d > 4095) d = 4095;
        res(k, d, (k < 4) ? "R4" : "R5");
      end else if (kind == 6) begin
        wr(4 + ($urandom % 8), $urandom % 4096, "R12");
      end else if (kind == 7) begin
        wr(12 + ($urandom % 4), ($urandom % 8 == 0) ? 4095 : $urandom % 16, "R9");
      end else if (kind == 8) begin
        wr(1, ($urandom % 2) ? 255 : $urandom % 256, "R7");
      end else begin
        wr(0, $urandom % 8, "R10");
      end
      if (i % 8 == 0) check_reg($urandom % 16, "R12");
    end

    done = 1;
    summary();
    $finish;
  end
endmodule